// File: doc/BRIEF.md
# Pending-Bit Set/Clear Engine

This block takes commands that mark an interrupt as pending or no longer pending and applies them to a pending bitmap held in memory. The bitmap stores one bit per interrupt ID and is packed eight IDs to a byte. Each command carries a 64-bit data word, and only its low 32 bits name the interrupt. The engine checks the ID against a limit derived from the configured ID width. It then reads the byte that holds the ID's bit. When the bit already has the requested value, the engine finishes without writing. Otherwise it changes that one bit and writes the byte back.

Commands arrive on a valid/ready stream, and only one command is in flight at a time. `cmd_ready` is high only while the engine is idle, so a sender holding `cmd_valid` waits until the previous command has finished. The memory side is a byte-wide request port with a valid/ready handshake. Responses come back on a valid strobe that the engine always accepts. Each request, read or write, gets exactly one response. While the memory holds `mem_req_ready` low, the engine keeps its request valid and unchanged.

After every completed write, the engine raises a one-cycle update strobe. This strobe tells the downstream priority selector to re-scan. The table base address and the configured ID width are plain inputs and must stay stable while `busy` is high.

Top module: `lpi_pend_engine`

## Requirements
- R1: `cmd_ready` is high exactly when the engine is idle. A command is accepted on a clock edge with `cmd_valid` and `cmd_ready` both high. `busy` is high from the cycle after acceptance until the command has been dropped or finished.
- R2: The interrupt ID is `cmd_data[31:0]`. Bits 63:32 of `cmd_data` have no effect on any memory access or result.
- R3: Let L = 1 << (`cfg_idbits` + 1). A command with ID greater than L is dropped: no memory request is issued and no update strobe follows. An ID equal to L is processed normally.
- R4: An accepted, in-range command first issues a read (`mem_req_write`=0) at address `tbl_base` + (ID >> 3).
- R5: A set command (`cmd_op`=1) that reads the bit already at 1, or a clear command (`cmd_op`=0) that reads it already at 0, issues no write and produces no update strobe.
- R6: In every other case, the engine issues one write to the same address. The written byte equals the read byte with only bit (ID mod 8) changed: forced to 1 for set, 0 for clear. No other byte of the bitmap changes.
- R7: `upd_req` is high for exactly one cycle: the cycle after the clock edge that accepts the write response. There is exactly one such pulse per write.
- R8: While `mem_req_valid` is high and `mem_req_ready` is low, the request stays valid and its address, write flag and data stay unchanged.
- R9: During and right after reset, `cmd_ready`=1, `busy`=0, `mem_req_valid`=0 and `upd_req`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_idbits | input | 5 | Configured ID width field; limit is 1 << (value + 1) |
| tbl_base | input | 32 | Byte address of the pending bitmap |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine idle, command will be taken |
| cmd_op | input | 1 | 1 = set pending, 0 = clear pending |
| cmd_data | input | 64 | Command data; low 32 bits are the ID |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | 32 | Byte address |
| mem_req_wdata | output | 8 | Write byte |
| mem_rsp_valid | input | 1 | Response strobe (read data or write completion) |
| mem_rsp_rdata | input | 8 | Read byte |
| busy | output | 1 | Command in progress |
| upd_req | output | 1 | One-cycle re-evaluation strobe |

## Verification
The hardest case to reach is a command whose bit already holds the target value, because that depends on the memory contents left by earlier commands. The bench draws IDs from a small window so that IDs repeat often. It also mixes set and clear commands at random, so redundant commands happen regularly. The memory model adds random request back-pressure and response delay, which exercises R8. Directed commands hit the ID exactly at the limit, the ID one above it, and data words with junk in the upper bits.

// File: rtl/lpi_pend_pkg.sv
package lpi_pend_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_RDREQ,
    ST_RDWAIT,
    ST_MODIFY,
    ST_WRREQ,
    ST_WRWAIT
  } eng_state_t;
endpackage

// File: rtl/lpi_pend_decode.sv
module lpi_pend_decode #(
  parameter int ID_W   = 32,
  parameter int ADDR_W = 32,
  parameter int IDB_W  = 5,
  parameter int BYTE_W = 8
) (
  input  logic [ID_W-1:0]          id,
  input  logic [IDB_W-1:0]         cfg_idbits,
  input  logic [ADDR_W-1:0]        tbl_base,
  output logic                     in_range,
  output logic [ADDR_W-1:0]        byte_addr,
  output logic [$clog2(BYTE_W)-1:0] bit_pos
);
  localparam int LIM_W = ID_W + 1;
  localparam int BIT_W = $clog2(BYTE_W);

  logic [LIM_W-1:0] limit;
  logic [IDB_W:0]   shamt;

  always_comb begin
    shamt     = {1'b0, cfg_idbits} + {{IDB_W{1'b0}}, 1'b1};
    limit     = {{(LIM_W-1){1'b0}}, 1'b1} << shamt;
    in_range  = ({1'b0, id} <= limit);
    byte_addr = tbl_base + ADDR_W'(id >> BIT_W);
    bit_pos   = id[BIT_W-1:0];
  end
endmodule

// File: rtl/lpi_pend_ctrl.sv
module lpi_pend_ctrl
  import lpi_pend_pkg::*;
#(
  parameter int ID_W   = 32,
  parameter int ADDR_W = 32,
  parameter int BYTE_W = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cmd_valid,
  output logic                      cmd_ready,
  input  logic                      cmd_op,
  input  logic [ID_W-1:0]           cmd_id,
  output logic [ID_W-1:0]           id_q,
  input  logic                      in_range,
  input  logic [ADDR_W-1:0]         byte_addr,
  input  logic [$clog2(BYTE_W)-1:0] bit_pos,
  output logic                      mem_req_valid,
  input  logic                      mem_req_ready,
  output logic                      mem_req_write,
  output logic [ADDR_W-1:0]         mem_req_addr,
  output logic [BYTE_W-1:0]         mem_req_wdata,
  input  logic                      mem_rsp_valid,
  input  logic [BYTE_W-1:0]         mem_rsp_rdata,
  output logic                      busy,
  output logic                      wr_done
);
  eng_state_t        st;
  logic              op_q;
  logic [BYTE_W-1:0] byte_q;
  logic [BYTE_W-1:0] mask;
  logic              cur_bit;

  always_comb begin
    mask          = {{(BYTE_W-1){1'b0}}, 1'b1} << bit_pos;
    cur_bit       = byte_q[bit_pos];
    cmd_ready     = (st == ST_IDLE);
    busy          = (st != ST_IDLE);
    mem_req_valid = (st == ST_RDREQ) || (st == ST_WRREQ);
    mem_req_write = (st == ST_WRREQ);
    mem_req_addr  = byte_addr;
    mem_req_wdata = op_q ? (byte_q | mask) : (byte_q & ~mask);
    wr_done       = (st == ST_WRWAIT) && mem_rsp_valid;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      id_q   <= '0;
      op_q   <= 1'b0;
      byte_q <= '0;
    end else begin
      case (st)
        ST_IDLE: if (cmd_valid) begin
          id_q <= cmd_id;
          op_q <= cmd_op;
          st   <= ST_CHECK;
        end
        ST_CHECK:  st <= in_range ? ST_RDREQ : ST_IDLE;
        ST_RDREQ:  if (mem_req_ready) st <= ST_RDWAIT;
        ST_RDWAIT: if (mem_rsp_valid) begin
          byte_q <= mem_rsp_rdata;
          st     <= ST_MODIFY;
        end
        ST_MODIFY: st <= (cur_bit == op_q) ? ST_IDLE : ST_WRREQ;
        ST_WRREQ:  if (mem_req_ready) st <= ST_WRWAIT;
        ST_WRWAIT: if (mem_rsp_valid) st <= ST_IDLE;
        default:   st <= ST_IDLE;
      endcase
    end
  end

  assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)
      && $stable(mem_req_write) && $stable(mem_req_wdata)));

  assert_one_bit_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_write) |-> ($countones(mem_req_wdata ^ byte_q) == 1));

  assert_idle_no_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> !mem_req_valid);

  assert_drop_to_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_CHECK && !in_range) |=> (cmd_ready && !mem_req_valid));

  assert_skip_no_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_MODIFY && cur_bit == op_q) |=> !mem_req_valid);
endmodule

// File: rtl/lpi_pend_notify.sv
module lpi_pend_notify (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_done,
  output logic upd_req
);
  always_ff @(posedge clk) begin
    if (!rst_n) upd_req <= 1'b0;
    else        upd_req <= wr_done;
  end

  assert_pulse_width_R7: assert property (@(posedge clk) disable iff (!rst_n)
    upd_req |=> !upd_req);

  assert_pulse_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(upd_req) |-> $past(wr_done));
endmodule

// File: rtl/lpi_pend_engine.sv
module lpi_pend_engine #(
  parameter int DATA_W = 64,
  parameter int ID_W   = 32,
  parameter int ADDR_W = 32,
  parameter int IDB_W  = 5,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDB_W-1:0]  cfg_idbits,
  input  logic [ADDR_W-1:0] tbl_base,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_op,
  input  logic [DATA_W-1:0] cmd_data,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [BYTE_W-1:0] mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [BYTE_W-1:0] mem_rsp_rdata,
  output logic              busy,
  output logic              upd_req
);
  localparam int BIT_W = $clog2(BYTE_W);

  logic [ID_W-1:0]   cmd_id;
  logic [ID_W-1:0]   id_q;
  logic              in_range;
  logic [ADDR_W-1:0] byte_addr;
  logic [BIT_W-1:0]  bit_pos;
  logic              wr_done;

  assign cmd_id = cmd_data[ID_W-1:0];

  lpi_pend_decode #(.ID_W(ID_W), .ADDR_W(ADDR_W), .IDB_W(IDB_W), .BYTE_W(BYTE_W)) u_dec (
    .id(id_q), .cfg_idbits(cfg_idbits), .tbl_base(tbl_base),
    .in_range(in_range), .byte_addr(byte_addr), .bit_pos(bit_pos)
  );

  lpi_pend_ctrl #(.ID_W(ID_W), .ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_id(cmd_id),
    .id_q(id_q), .in_range(in_range), .byte_addr(byte_addr), .bit_pos(bit_pos),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_rdata(mem_rsp_rdata), .busy(busy), .wr_done(wr_done)
  );

  lpi_pend_notify u_ntf (.clk(clk), .rst_n(rst_n), .wr_done(wr_done), .upd_req(upd_req));

  assert_busy_excl_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> busy);
endmodule

// File: tb/lpi_pend_engine_test.sv
module lpi_pend_engine_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  cfg_idbits = 5'd9;
  logic [31:0] tbl_base = 32'd16;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic        cmd_op = 1'b0;
  logic [63:0] cmd_data = '0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic        mem_req_write;
  logic [31:0] mem_req_addr;
  logic [7:0]  mem_req_wdata;
  logic        mem_rsp_valid = 1'b0;
  logic [7:0]  mem_rsp_rdata = '0;
  logic        busy;
  logic        upd_req;

  always #2.5 clk = ~clk;

  lpi_pend_engine uut (
    .clk(clk), .rst_n(rst_n), .cfg_idbits(cfg_idbits), .tbl_base(tbl_base),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_data(cmd_data),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_rdata(mem_rsp_rdata), .busy(busy), .upd_req(upd_req)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [7:0] mem [256];
  logic [7:0] ref_mem [256];
  int n_rd = 0, n_wr = 0, n_upd = 0;
  logic [31:0] last_rd_addr = '0;

  // memory model, driven away from the active edge
  int mstate = 0;
  int mdelay = 0;
  logic [7:0] cap_addr;
  always @(negedge clk) begin
    if (upd_req) n_upd++;
    case (mstate)
      0: if (mem_req_valid && ($urandom % 3 != 0)) begin
           mem_req_ready = 1'b1;
           cap_addr = mem_req_addr[7:0];
           if (mem_req_write) begin
             mem[cap_addr] = mem_req_wdata;
             n_wr++;
           end else begin
             n_rd++;
             last_rd_addr = mem_req_addr;
           end
           mstate = 1;
         end
      1: begin mem_req_ready = 1'b0; mdelay = $urandom % 4; mstate = 2; end
      2: if (mdelay == 0) begin
           mem_rsp_valid = 1'b1; mem_rsp_rdata = mem[cap_addr]; mstate = 3;
         end else mdelay--;
      default: begin mem_rsp_valid = 1'b0; mstate = 0; end
    endcase
  end

  function automatic longint exp_limit(input logic [4:0] b);
    return longint'(1) << (int'(b) + 1);
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_cmd(input bit op, input logic [63:0] data);
    int rd0, wr0, up0;
    logic [31:0] id;
    bit inr, change;
    int a, b;
    logic [7:0] nb;
    id = data[31:0];
    inr = longint'(id) <= exp_limit(cfg_idbits);
    a = int'(tbl_base) + int'(id >> 3);
    b = int'(id[2:0]);
    rd0 = n_rd; wr0 = n_wr; up0 = n_upd;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_data = data;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    check(busy == 1'b1, "R1 busy after accept", busy, 1);
    check(cmd_ready == 1'b0, "R1 not ready while busy", cmd_ready, 0);
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
    change = 0;
    if (inr) begin
      change = (ref_mem[a[7:0]][b] != op);
      nb = ref_mem[a[7:0]];
      nb[b] = op;
      ref_mem[a[7:0]] = nb;
      check(last_rd_addr == 32'(a), "R4 read address", longint'(last_rd_addr), a);
    end
    check(n_rd - rd0 == (inr ? 1 : 0), "R3 read count", n_rd - rd0, inr ? 1 : 0);
    check(n_wr - wr0 == (change ? 1 : 0), "R5 write count", n_wr - wr0, change ? 1 : 0);
    check(n_upd - up0 == (change ? 1 : 0), "R7 update pulses", n_upd - up0, change ? 1 : 0);
    if (inr)
      check(mem[a[7:0]] == ref_mem[a[7:0]], "R6 byte value", mem[a[7:0]], ref_mem[a[7:0]]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 256; i++) begin
      mem[i] = 8'($urandom);
      ref_mem[i] = mem[i];
    end
    repeat (3) @(negedge clk);
    // R9 reset values
    check(cmd_ready == 1'b1, "R9 cmd_ready in reset", cmd_ready, 1);
    check(busy == 1'b0, "R9 busy in reset", busy, 0);
    check(mem_req_valid == 1'b0, "R9 req in reset", mem_req_valid, 0);
    check(upd_req == 1'b0, "R9 upd in reset", upd_req, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(cmd_ready == 1'b1 && busy == 1'b0, "R9 idle after reset", busy, 0);

    // directed: set then redundant set, clear then redundant clear
    ref_mem[16 + 5][3] = 1'b0; mem[16 + 5][3] = 1'b0;
    run_cmd(1'b1, 64'd43);
    run_cmd(1'b1, 64'd43);
    run_cmd(1'b0, 64'd43);
    run_cmd(1'b0, 64'd43);
    // R2 junk in upper half
    run_cmd(1'b1, {32'hDEAD_BEEF, 32'd100});
    run_cmd(1'b0, {32'hFFFF_FFFF, 32'd100});
    // R3 limit boundaries, cfg 9 -> limit 1024
    run_cmd(1'b1, 64'd1024);
    run_cmd(1'b1, 64'd1025);
    run_cmd(1'b0, 64'h0000_0000_FFFF_FFFF);
    // R3 small config, limit 8
    cfg_idbits = 5'd2;
    run_cmd(1'b1, 64'd8);
    run_cmd(1'b0, 64'd8);
    run_cmd(1'b1, 64'd9);
    cfg_idbits = 5'd9;

    // random mix over a narrow ID window to force repeats
    for (int k = 0; k < 300; k++) begin
      logic [63:0] d;
      d = {32'($urandom), 32'($urandom % 48)};
      if ($urandom % 10 == 0) d[31:0] = 32'd1000 + 32'($urandom % 60);
      run_cmd(1'($urandom), d);
    end

    // R6 no other byte changed
    for (int i = 0; i < 256; i++)
      if (mem[i] != ref_mem[i])
        check(1'b0, "R6 stray byte change", mem[i], ref_mem[i]);
    checks++;

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule